// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter clocked from a selectable prescaler tap. It runs in one of two modes. In watchdog mode, software must rewrite the counter before it rolls over. A rollover starts a long internal reset pulse and, if enabled, a shorter external reset pulse. In interval mode, a rollover sets an overflow flag and raises an interrupt request. The counter then wraps and keeps counting.

Every write is a 16-bit word. The upper byte is a key, and a write with the wrong key is dropped. Two word addresses exist. Offset 0 carries the counter and the mode/control register, each selected by its own key. Offset 2 carries the reset-cause flag and the reset-output enable. Reads are plain byte reads at offsets 0, 1 and 3. While the internal reset pulse is active, the block holds its own control state and counter cleared. It keeps the reset-cause flag, so software can identify the reset after restart.

Top module: `kwdt_top`

## Requirements
- R1: After rstN is released, every byte read (offsets 0 to 3) returns 0x00, and irqOut, intRstOut and extRstOut are 0.
- R2: A word write at offset 0 with key 0x5A loads the counter from the low byte. A word write at offset 0 with key 0xA5 loads the control byte: bit 6 selects the mode (1 = watchdog), bit 5 enables the timer, and bits 2:0 are the clock select. In the same write, bit 7 = 0 clears the overflow flag and bit 7 = 1 leaves it unchanged. A write at offset 0 with any other key changes nothing.
- R3: At offset 2, key 0xA5 with low byte 0x00 clears the reset-cause flag and nothing else. Key 0x5A sets the reset-output enable from low-byte bit 6. Key 0xA5 with a nonzero low byte, and any other key, changes nothing.
- R4: Offset 0 reads the control byte as {overflow flag, mode, enable, 2'b00, clock select}. Offset 1 reads the counter. Offset 3 reads {reset-cause flag, reset-output enable, 6'b0}. Offset 2 reads 0x00.
- R5: Clock select 0 to 7 picks a period of 2, 8, 32, 64, 128, 512, 2048 or 4096 cycles. The prescaler is held at zero while the timer is disabled. After the write that enables the timer, the counter first reads 1 exactly one period later and then steps once per period.
- R6: While the enable bit is 0, the counter is held at 0 and counter writes have no effect. Disabling a running timer reads 0 one cycle after the write.
- R7: In interval mode, a rollover from 0xFF sets the overflow flag and raises irqOut (irqOut = flag AND interval mode). The counter wraps to 0 and continues counting, and no reset pulse occurs. Clearing the flag drops irqOut.
- R8: In watchdog mode, a rollover from 0xFF drives intRstOut high for exactly 518 cycles, starting in the cycle after the rollover edge, and sets the reset-cause flag.
- R9: On the same rollover, extRstOut goes high for exactly 132 cycles, starting together with intRstOut, if the reset-output enable is 1. If the enable is 0, extRstOut stays 0.
- R10: While intRstOut is high, the control byte and the counter are held at 0 and all writes are ignored. The reset-cause flag and the reset-output enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| busAddr | input | 2 | Byte offset for reads, word offset (0 or 2) for writes |
| busWrEn | input | 1 | Word write strobe |
| busWdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| busRdata | output | 8 | Read data at busAddr |
| irqOut | output | 1 | Interval overflow interrupt request |
| intRstOut | output | 1 | Internal reset pulse, 518 cycles |
| extRstOut | output | 1 | External reset pulse, 132 cycles, active high |

## Verification
All eight clock-select codes are walked from a table. For each code, the bench checks that the counter is still zero one cycle before the expected period and reads one exactly at it, which separates every tap from its neighbours and detects an off-by-one in the prescaler. Three key patterns are applied at both write offsets: the right key, a foreign key, and the reset-flag key with a nonzero value. These separate the accepted writes from the ignored ones. A rollover is forced in interval mode and then twice in watchdog mode, once with the external output enabled and once with it disabled. Each case checks the exact pulse lengths, the onset cycle and the reset-cause flag, and the bench tries writes during the pulse to show they are locked out.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int CNT_W = 8;
  localparam int CKS_W = 3;
  localparam logic [7:0] KEY_REG = 8'hA5;
  localparam logic [7:0] KEY_CNT = 8'h5A;

  typedef struct packed {
    logic             runEn;
    logic [CKS_W-1:0] cks;
    logic             cntLoad;
    logic [CNT_W-1:0] cntVal;
    logic             startInt;
    logic             startExt;
  } strobes_t;
endpackage

// File: rtl/kwdt_datapath.sv
module kwdt_datapath
  import kwdt_pkg::*;
#(
  parameter int PRESC_W        = 12,
  parameter int INT_RST_CYCLES = 518,
  parameter int EXT_RST_CYCLES = 132
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfTick,
  output logic             intRst,
  output logic             extRst
);
  localparam int INT_W = $clog2(INT_RST_CYCLES + 1);
  localparam int EXT_W = $clog2(EXT_RST_CYCLES + 1);
  localparam logic [INT_W-1:0] INT_LOAD = INT_W'(INT_RST_CYCLES);
  localparam logic [EXT_W-1:0] EXT_LOAD = EXT_W'(EXT_RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] tapMask;
  logic               tick;
  logic [INT_W-1:0]   intLeft;
  logic [EXT_W-1:0]   extLeft;

  // Tap shift per select code: periods 2,8,32,64,128,512,2048,4096
  function automatic int tapShift(input logic [CKS_W-1:0] sel);
    case (sel)
      3'd0: tapShift = 1;
      3'd1: tapShift = 3;
      3'd2: tapShift = 5;
      3'd3: tapShift = 6;
      3'd4: tapShift = 7;
      3'd5: tapShift = 9;
      3'd6: tapShift = 11;
      default: tapShift = 12;
    endcase
  endfunction

  always_comb begin
    tapMask = PRESC_W'((64'd1 << tapShift(strb.cks)) - 64'd1);
    tick    = strb.runEn && ((presc & tapMask) == tapMask);
    ovfTick = tick && (cnt == CNT_MAX) && !strb.cntLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               presc <= '0;
    else if (!strb.runEn)    presc <= '0;
    else                     presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (!strb.runEn)   cnt <= '0;
    else if (strb.cntLoad)  cnt <= strb.cntVal;
    else if (tick)          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intLeft <= '0;
      extLeft <= '0;
    end else begin
      if (strb.startInt)        intLeft <= INT_LOAD;
      else if (intLeft != '0)   intLeft <= intLeft - 1'b1;
      if (strb.startExt)        extLeft <= EXT_LOAD;
      else if (extLeft != '0)   extLeft <= extLeft - 1'b1;
    end
  end

  assign intRst = (intLeft != '0);
  assign extRst = (extLeft != '0);

  // External pulse is shorter and starts together with the internal one
  assert_ext_within_int_R9: assert property (@(posedge clk) disable iff (!rstN)
    extRst |-> intRst);

  // Disabled timer leaves the counter at zero on the next cycle
  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runEn |=> (cnt == '0));
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [15:0]      busWdata,
  output logic [7:0]       busRdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovfTick,
  input  logic             intRst,
  output strobes_t         strb,
  output logic             irqOut
);
  logic             ovfFlag, wdMode, tmrEn;
  logic [CKS_W-1:0] cksSel;
  logic             rstFlag, rstOutEn;
  logic [7:0]       key, val;
  logic             wrOk, csrWr, cntWr, flagClr, oeWr;
  logic             intervalOvf, watchdogOvf;
  logic [7:0]       csrByte;

  always_comb begin
    key         = busWdata[15:8];
    val         = busWdata[7:0];
    wrOk        = busWrEn && !intRst;
    csrWr       = wrOk && (busAddr == 2'd0) && (key == KEY_REG);
    cntWr       = wrOk && (busAddr == 2'd0) && (key == KEY_CNT);
    flagClr     = wrOk && (busAddr == 2'd2) && (key == KEY_REG) && (val == 8'h00);
    oeWr        = wrOk && (busAddr == 2'd2) && (key == KEY_CNT);
    intervalOvf = ovfTick && !wdMode;
    watchdogOvf = ovfTick && wdMode;
    csrByte     = {ovfFlag, wdMode, tmrEn, 2'b00, cksSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      wdMode  <= 1'b0;
      tmrEn   <= 1'b0;
      cksSel  <= '0;
    end else if (intRst) begin
      ovfFlag <= 1'b0;
      wdMode  <= 1'b0;
      tmrEn   <= 1'b0;
      cksSel  <= '0;
    end else begin
      if (csrWr) begin
        wdMode <= val[6];
        tmrEn  <= val[5];
        cksSel <= val[CKS_W-1:0];
        if (!val[7]) ovfFlag <= 1'b0;
      end
      if (intervalOvf) ovfFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstFlag  <= 1'b0;
      rstOutEn <= 1'b0;
    end else begin
      if (watchdogOvf)  rstFlag <= 1'b1;
      else if (flagClr) rstFlag <= 1'b0;
      if (oeWr) rstOutEn <= val[6];
    end
  end

  always_comb begin
    strb.runEn    = tmrEn && !intRst;
    strb.cks      = cksSel;
    strb.cntLoad  = cntWr;
    strb.cntVal   = val[CNT_W-1:0];
    strb.startInt = watchdogOvf;
    strb.startExt = watchdogOvf && rstOutEn;
  end

  always_comb begin
    case (busAddr)
      2'd0:    busRdata = csrByte;
      2'd1:    busRdata = cnt;
      2'd3:    busRdata = {rstFlag, rstOutEn, 6'b0};
      default: busRdata = 8'h00;
    endcase
  end

  assign irqOut = ovfFlag && !wdMode;

  // A write with a foreign key at offset 0 leaves the control byte alone
  assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0 && key != KEY_REG && !ovfTick && !intRst)
    |=> $stable(csrByte));

  // Interval rollover raises the flag without any reset
  assert_interval_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    intervalOvf |=> (ovfFlag && !intRst));

  // A reset pulse never starts without the cause flag being recorded
  assert_cause_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intRst) |-> rstFlag);

  // Writes during the reset pulse cannot alter the reset-output enable
  assert_locked_oe_R10: assert property (@(posedge clk) disable iff (!rstN)
    intRst |=> $stable(rstOutEn));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PRESC_W        = 12,
  parameter int INT_RST_CYCLES = 518,
  parameter int EXT_RST_CYCLES = 132
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic [15:0] busWdata,
  output logic [7:0]  busRdata,
  output logic        irqOut,
  output logic        intRstOut,
  output logic        extRstOut
);
  strobes_t         strb;
  logic [CNT_W-1:0] cnt;
  logic             ovfTick;

  kwdt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .cnt(cnt), .ovfTick(ovfTick),
    .intRst(intRstOut), .strb(strb), .irqOut(irqOut)
  );

  kwdt_datapath #(
    .PRESC_W(PRESC_W), .INT_RST_CYCLES(INT_RST_CYCLES),
    .EXT_RST_CYCLES(EXT_RST_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .ovfTick(ovfTick),
    .intRst(intRstOut), .extRst(extRstOut)
  );
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [7:0]  busRdata;
  logic        irqOut, intRstOut, extRstOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int intHigh = 0;
  int extHigh = 0;

  // Clock select code -> period in cycles (R5)
  localparam logic [15:0] PERIODS [8] = '{16'd2, 16'd8, 16'd32, 16'd64,
                                          16'd128, 16'd512, 16'd2048, 16'd4096};

  kwdt_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .intRstOut(intRstOut), .extRstOut(extRstOut)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (intRstOut) intHigh++;
    if (extRstOut) extHigh++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    busAddr  = a;
    busWdata = d;
    busWrEn  = 1'b1;
    @(negedge clk);
    busWrEn  = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [7:0] rd;

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), rd);
      check("R1 read", rd, 0);
    end
    check("R1 outputs", {irqOut, intRstOut, extRstOut}, 0);

    // R2: foreign key at offset 0 ignored
    busWrite(2'd0, 16'h3360);
    busRead(2'd0, rd);
    check("R2 bad key", rd, 8'h00);

    // R6: counter write while disabled has no effect
    busWrite(2'd0, 16'h5A40);
    @(negedge clk);
    busRead(2'd1, rd);
    check("R6 load while off", rd, 0);

    // R5/R4: table of clock selects walked by one loop
    for (int k = 0; k < 8; k++) begin
      busWrite(2'd0, 16'hA500);
      busWrite(2'd0, 16'hA520 | 16'(k));
      busRead(2'd0, rd);
      check("R4 ctrl read", rd, 8'h20 | k);
      waitCycles(int'(PERIODS[k]) - 1);
      busRead(2'd1, rd);
      check("R5 before period", rd, 0);
      @(negedge clk);
      busRead(2'd1, rd);
      check("R5 at period", rd, 1);
    end

    // R6: disabling clears the counter one cycle later
    busWrite(2'd0, 16'hA520);
    waitCycles(10);
    busWrite(2'd0, 16'hA500);
    @(negedge clk);
    busRead(2'd1, rd);
    check("R6 disable clears", rd, 0);

    // R7: interval rollover
    busWrite(2'd0, 16'hA520);
    busWrite(2'd0, 16'h5AFE);
    busRead(2'd1, rd);
    check("R2 counter load", rd, 8'hFE);
    waitCycles(3);
    busRead(2'd1, rd);
    check("R7 wrap", rd, 0);
    busRead(2'd0, rd);
    check("R7 flag", rd, 8'hA0);
    check("R7 irq", irqOut, 1);
    check("R7 no reset", intRstOut, 0);
    waitCycles(2);
    busRead(2'd1, rd);
    check("R7 keeps counting", rd, 1);
    busWrite(2'd0, 16'hA5A0);
    check("R2 flag write 1 keeps", irqOut, 1);
    busWrite(2'd0, 16'hA520);
    check("R7 irq cleared", irqOut, 0);
    busWrite(2'd0, 16'hA500);

    // R3: reset-output enable and foreign keys at offset 2
    busWrite(2'd2, 16'h5A40);
    busRead(2'd3, rd);
    check("R3 oe set", rd, 8'h40);
    busWrite(2'd2, 16'h1200);
    busRead(2'd3, rd);
    check("R3 bad key", rd, 8'h40);
    busRead(2'd2, rd);
    check("R4 offset 2", rd, 0);

    // R8/R9/R10: watchdog rollover with external output enabled
    busWrite(2'd0, 16'hA560);
    busWrite(2'd0, 16'h5AFE);
    intHigh = 0;
    extHigh = 0;
    waitCycles(2);
    check("R8 not early", intRstOut, 0);
    @(negedge clk);
    check("R8 onset", intRstOut, 1);
    check("R9 onset", extRstOut, 1);
    busRead(2'd3, rd);
    check("R8 cause flag", rd, 8'hC0);
    busWrite(2'd0, 16'hA520);
    busWrite(2'd2, 16'h5A00);
    busWrite(2'd0, 16'h5A33);
    busRead(2'd0, rd);
    check("R10 ctrl locked", rd, 0);
    busRead(2'd1, rd);
    check("R10 counter locked", rd, 0);
    busRead(2'd3, rd);
    check("R10 oe kept", rd, 8'hC0);
    while (intRstOut && cycles < 140000) @(negedge clk);
    check("R8 int length", intHigh, 518);
    check("R9 ext length", extHigh, 132);
    busWrite(2'd2, 16'hA501);
    busRead(2'd3, rd);
    check("R3 nonzero value ignored", rd, 8'hC0);
    busWrite(2'd2, 16'hA500);
    busRead(2'd3, rd);
    check("R3 flag clear", rd, 8'h40);

    // R9: watchdog rollover with external output disabled
    busWrite(2'd2, 16'h5A00);
    busWrite(2'd0, 16'hA560);
    busWrite(2'd0, 16'h5AFE);
    intHigh = 0;
    extHigh = 0;
    waitCycles(3);
    check("R8 onset again", intRstOut, 1);
    while (intRstOut && cycles < 140000) @(negedge clk);
    check("R8 int length again", intHigh, 518);
    check("R9 ext disabled", extHigh, 0);
    busRead(2'd3, rd);
    check("R8 flag again", rd, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule